// File: doc/BRIEF.md
# Multi-Word DMA Strobe Timing Generator

This block paces the handshake between a storage drive and a memory-side DMA engine, one word at a time. When the host starts a transfer, the block latches the word count, one of four timing types and the direction. It then steps through the words. For each word it raises the acknowledge and holds the read or write strobe for the active time of the chosen type. After that it keeps the strobe low for the recovery time and only then counts the word as moved. The data path and address generation sit outside this block. It only produces the timing and the bookkeeping of the remaining words.

One clock period is one timing tick. The number of active and recovery ticks for each type is a parameter. The drive's request line gates every new word. If the request is low, the block waits with the acknowledge low. While waiting, the host may abort the transfer. The block accepts only one transfer at a time. A second start while busy is reported and otherwise has no effect. A transfer that ends with words still outstanding is reported as failed.

Top module: `dmaStrobeGen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy, dmaAck, both strobes, done, xferFail and startErr are low and residue is 0.
- R2: A start pulse sampled while idle latches wordCount, timingType and dirWrite. From the next cycle, busy is high and residue equals the latched count.
- R3: A word is served as a fixed sequence: dmaAck and the strobe are high for the active ticks, then dmaAck stays high with the strobe low for the recovery ticks. The default ticks (active/recovery) are: type code 0 = 4/5, 1 = 3/4, 2 = 2/2, 3 = 1/2. While the request is held, dmaAck stays high without a gap across consecutive words.
- R4: When the latched dirWrite is 1, wrStrobe carries the active phase. When it is 0, rdStrobe carries it. The two strobes are never high together.
- R5: residue decrements by one on the clock edge that ends each word's recovery phase, and changes at no other time during a transfer.
- R6: At the end of recovery, the next word starts in the following cycle if dmaReq is high. Otherwise the block waits with dmaAck low and starts the next word one cycle after dmaReq is seen high again.
- R7: When the last word's recovery ends, done is high for exactly one cycle, busy is low in that cycle, xferFail is low, and residue is 0.
- R8: If abort is high and dmaReq is low at a point where the next word would start, the transfer ends. done pulses with xferFail high, and residue keeps the number of words not moved. If dmaReq is high at that point, it takes priority over abort.
- R9: A start sampled while busy raises startErr for one cycle on the next cycle. The running transfer, its count, type and direction are unaffected.
- R10: A start with wordCount 0 produces done, with xferFail low, two cycles after the start is sampled. dmaAck is never raised.
- R11: Changes to timingType and dirWrite during a transfer have no effect on its timing or direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing tick per period |
| rstN | input | 1 | Asynchronous active-low reset |
| timingType | input | 2 | Timing type code, sampled at start |
| dirWrite | input | 1 | 1 = write to device, 0 = read from device, sampled at start |
| start | input | 1 | Start pulse for a new transfer |
| wordCount | input | CNT_W | Number of words, sampled at start |
| dmaReq | input | 1 | Drive's DMA request |
| abort | input | 1 | Ends a transfer that is waiting for the request |
| dmaAck | output | 1 | DMA acknowledge for the current word |
| rdStrobe | output | 1 | Read strobe, active phase |
| wrStrobe | output | 1 | Write strobe, active phase |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| xferFail | output | 1 | With done: transfer ended with words outstanding |
| startErr | output | 1 | One-cycle pulse: start while busy was ignored |
| residue | output | CNT_W | Words still to be moved |

## Verification
A held request with each of the four type codes in both directions separates the per-type tick counts and the choice of strobe. Measured strobe and acknowledge run lengths expose an off-by-one in either phase. A request that drops mid-transfer and later returns tells the stall path apart from the direct word-to-word path. The abort, zero-count and start-while-busy patterns each isolate one ending or rejection path. Changing the type and direction inputs in the middle of a transfer shows that only the values latched at start are used.

// File: rtl/dmaStrobePkg.sv
package dmaStrobePkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RECOV  = 2'd3
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadXfer;    // latch count, type, direction
    logic loadActive;  // load phase counter with active ticks
    logic loadRecov;   // load phase counter with recovery ticks
    logic stepPhase;   // count phase down
    logic dropWord;    // one word completed
  } dpCtrl_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmaStrobeDatapath.sv
module dmaStrobeDatapath
  import dmaStrobePkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACT_A = 4, parameter int REC_A = 5,
  parameter int ACT_B = 3, parameter int REC_B = 4,
  parameter int ACT_C = 2, parameter int REC_C = 2,
  parameter int ACT_D = 1, parameter int REC_D = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [CNT_W-1:0] wordCount,
  input  logic [1:0]       typeIn,
  input  logic             dirIn,
  output logic             phaseZero,
  output logic             residueZero,
  output logic             residueOne,
  output logic             dirLatched,
  output logic [CNT_W-1:0] residue
);

  localparam int TICK_MAX = maxInt(maxInt(maxInt(ACT_A, ACT_B), maxInt(ACT_C, ACT_D)),
                                   maxInt(maxInt(REC_A, REC_B), maxInt(REC_C, REC_D)));
  localparam int PH_W = $clog2(TICK_MAX + 1);
  localparam int N_TYPES = 4;

  logic [PH_W-1:0]  phaseCnt;
  logic [1:0]       typeReg;
  logic [CNT_W-1:0] wordsLeft;
  logic             dirReg;
  logic [PH_W-1:0]  actTab [N_TYPES];
  logic [PH_W-1:0]  recTab [N_TYPES];

  // tick tables, loaded as count-1 so the last tick is the zero state
  genvar t;
  generate
    for (t = 0; t < N_TYPES; t++) begin : gTick
      localparam int ACT_T = (t == 0) ? ACT_A : (t == 1) ? ACT_B : (t == 2) ? ACT_C : ACT_D;
      localparam int REC_T = (t == 0) ? REC_A : (t == 1) ? REC_B : (t == 2) ? REC_C : REC_D;
      assign actTab[t] = PH_W'(ACT_T - 1);
      assign recTab[t] = PH_W'(REC_T - 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeReg <= '0;
      dirReg  <= 1'b0;
    end else if (ctrl.loadXfer) begin
      typeReg <= typeIn;
      dirReg  <= dirIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctrl.loadActive) begin
      phaseCnt <= actTab[typeReg];
    end else if (ctrl.loadRecov) begin
      phaseCnt <= recTab[typeReg];
    end else if (ctrl.stepPhase && phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordsLeft <= '0;
    end else if (ctrl.loadXfer) begin
      wordsLeft <= wordCount;
    end else if (ctrl.dropWord && wordsLeft != '0) begin
      wordsLeft <= wordsLeft - 1'b1;
    end
  end

  assign phaseZero   = (phaseCnt == '0);
  assign residueZero = (wordsLeft == '0);
  assign residueOne  = (wordsLeft == CNT_W'(1));
  assign dirLatched  = dirReg;
  assign residue     = wordsLeft;

endmodule

// File: rtl/dmaStrobeControl.sv
module dmaStrobeControl
  import dmaStrobePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    dmaReq,
  input  logic    abort,
  input  logic    phaseZero,
  input  logic    residueZero,
  input  logic    residueOne,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    ackOn,
  output logic    strobeOn,
  output logic    done,
  output logic    xferFail,
  output logic    startErr
);

  xferState_t state, stateNext;
  logic finish, finishFail;

  always_comb begin
    stateNext  = state;
    ctrl       = '0;
    finish     = 1'b0;
    finishFail = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadXfer = 1'b1;
          stateNext     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (residueZero) begin
          finish    = 1'b1;
          stateNext = ST_IDLE;
        end else if (dmaReq) begin
          ctrl.loadActive = 1'b1;
          stateNext       = ST_ACTIVE;
        end else if (abort) begin
          finish     = 1'b1;
          finishFail = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_ACTIVE: begin
        if (phaseZero) begin
          ctrl.loadRecov = 1'b1;
          stateNext      = ST_RECOV;
        end else begin
          ctrl.stepPhase = 1'b1;
        end
      end
      ST_RECOV: begin
        if (!phaseZero) begin
          ctrl.stepPhase = 1'b1;
        end else begin
          ctrl.dropWord = 1'b1;
          if (residueOne) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else if (dmaReq) begin
            ctrl.loadActive = 1'b1;
            stateNext       = ST_ACTIVE;
          end else if (abort) begin
            finish     = 1'b1;
            finishFail = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      xferFail <= 1'b0;
      startErr <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= finish;
      xferFail <= finish & finishFail;
      startErr <= start & (state != ST_IDLE);
    end
  end

  assign busy     = (state != ST_IDLE);
  assign ackOn    = (state == ST_ACTIVE) || (state == ST_RECOV);
  assign strobeOn = (state == ST_ACTIVE);

endmodule

// File: rtl/dmaStrobeGen.sv
module dmaStrobeGen
  import dmaStrobePkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACT_A = 4, parameter int REC_A = 5,
  parameter int ACT_B = 3, parameter int REC_B = 4,
  parameter int ACT_C = 2, parameter int REC_C = 2,
  parameter int ACT_D = 1, parameter int REC_D = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       timingType,
  input  logic             dirWrite,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             dmaReq,
  input  logic             abort,
  output logic             dmaAck,
  output logic             rdStrobe,
  output logic             wrStrobe,
  output logic             busy,
  output logic             done,
  output logic             xferFail,
  output logic             startErr,
  output logic [CNT_W-1:0] residue
);

  dpCtrl_t ctrl;
  logic phaseZero, residueZero, residueOne, dirLatched, strobeOn;

  dmaStrobeControl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .dmaReq(dmaReq), .abort(abort),
    .phaseZero(phaseZero), .residueZero(residueZero), .residueOne(residueOne),
    .ctrl(ctrl), .busy(busy), .ackOn(dmaAck), .strobeOn(strobeOn),
    .done(done), .xferFail(xferFail), .startErr(startErr)
  );

  dmaStrobeDatapath #(
    .CNT_W(CNT_W),
    .ACT_A(ACT_A), .REC_A(REC_A), .ACT_B(ACT_B), .REC_B(REC_B),
    .ACT_C(ACT_C), .REC_C(REC_C), .ACT_D(ACT_D), .REC_D(REC_D)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wordCount(wordCount),
    .typeIn(timingType), .dirIn(dirWrite),
    .phaseZero(phaseZero), .residueZero(residueZero), .residueOne(residueOne),
    .dirLatched(dirLatched), .residue(residue)
  );

  assign rdStrobe = strobeOn & ~dirLatched;
  assign wrStrobe = strobeOn & dirLatched;

endmodule

// File: rtl/dmaStrobeChk.sv
module dmaStrobeChk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             dmaAck,
  input logic             rdStrobe,
  input logic             wrStrobe,
  input logic             done,
  input logic             xferFail,
  input logic             startErr,
  input logic [CNT_W-1:0] residue
);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  assert_strobe_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> dmaAck);

  assert_ack_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> busy);

  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferFail |-> done);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> startErr);

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dmaAck) |=> $stable(residue));

endmodule

bind dmaStrobeGen dmaStrobeChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .dmaAck(dmaAck),
  .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .done(done), .xferFail(xferFail),
  .startErr(startErr), .residue(residue)
);

// File: tb/tb_dmaStrobeGen.sv
module tb_dmaStrobeGen;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] timingType = 2'd0;
  logic dirWrite = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] wordCount = '0;
  logic dmaReq = 1'b0;
  logic abort = 1'b0;
  logic dmaAck, rdStrobe, wrStrobe, busy, done, xferFail, startErr;
  logic [CNT_W-1:0] residue;

  always #10 clk = ~clk;

  dmaStrobeGen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .timingType(timingType), .dirWrite(dirWrite),
    .start(start), .wordCount(wordCount), .dmaReq(dmaReq), .abort(abort),
    .dmaAck(dmaAck), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busy(busy),
    .done(done), .xferFail(xferFail), .startErr(startErr), .residue(residue)
  );

  int nCompared = 0;
  int nMismatch = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int actTicks [4] = '{4, 3, 2, 1};
  int recTicks [4] = '{5, 4, 2, 2};
  int mMode = 0;      // 0 idle, 1 waiting, 2 active, 3 recovery
  int mLeft = 0;      // ticks left in current phase
  int mWords = 0;
  int mType = 0;
  bit mWr = 0;
  bit mDone = 0, mFail = 0, mErr = 0;
  bit cmpOn = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mWords = 0; mType = 0; mWr = 0;
      mDone = 0; mFail = 0; mErr = 0;
    end else begin
      mDone = 0; mFail = 0;
      mErr = start && (mMode != 0);
      case (mMode)
        0: if (start) begin
             mWords = int'(wordCount); mType = int'(timingType); mWr = dirWrite; mMode = 1;
           end
        1: if (mWords == 0) begin mDone = 1; mMode = 0; end
           else if (dmaReq) begin mMode = 2; mLeft = actTicks[mType]; end
           else if (abort) begin mDone = 1; mFail = 1; mMode = 0; end
        2: begin
             mLeft--;
             if (mLeft == 0) begin mMode = 3; mLeft = recTicks[mType]; end
           end
        default: begin
             mLeft--;
             if (mLeft == 0) begin
               mWords--;
               if (mWords == 0) begin mDone = 1; mMode = 0; end
               else if (dmaReq) begin mMode = 2; mLeft = actTicks[mType]; end
               else if (abort) begin mDone = 1; mFail = 1; mMode = 0; end
               else mMode = 1;
             end
           end
      endcase
    end
  end

  // ---------------- compare and monitor, mid-cycle after the rising edge ----------------
  int strobeRun = 0, lastStrobeRun = 0, ackRun = 0, lastAckRun = 0;
  bit sawErr = 0, sawFail = 0, sawAck = 0, sawDone = 0;
  int lastResidueAtDone = 0;

  always begin
    @(posedge clk);
    #5;
    if (cmpOn) begin
      check("R3", "dmaAck", int'(dmaAck), int'(mMode == 2 || mMode == 3));
      check("R4", "rdStrobe", int'(rdStrobe), int'(mMode == 2 && !mWr));
      check("R4", "wrStrobe", int'(wrStrobe), int'(mMode == 2 && mWr));
      check("R2", "busy", int'(busy), int'(mMode != 0));
      check("R7", "done", int'(done), int'(mDone));
      check("R8", "xferFail", int'(xferFail), int'(mFail));
      check("R9", "startErr", int'(startErr), int'(mErr));
      check("R5", "residue", int'(residue), mWords);
    end
    if (rdStrobe || wrStrobe) strobeRun++;
    else if (strobeRun != 0) begin lastStrobeRun = strobeRun; strobeRun = 0; end
    if (dmaAck) begin ackRun++; sawAck = 1; end
    else if (ackRun != 0) begin lastAckRun = ackRun; ackRun = 0; end
    if (startErr) sawErr = 1;
    if (xferFail) sawFail = 1;
    if (done) begin sawDone = 1; lastResidueAtDone = int'(residue); end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog expired, run hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic clearFlags();
    sawErr = 0; sawFail = 0; sawAck = 0; sawDone = 0;
    lastStrobeRun = 0; lastAckRun = 0;
  endtask

  task automatic launch(input int ty, input bit wr, input int cnt);
    timingType = 2'(ty); dirWrite = wr; wordCount = CNT_W'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "dmaAck in reset", int'(dmaAck), 0);
    check("R1", "residue in reset", int'(residue), 0);
    rstN = 1'b1;
    cmpOn = 1;
    @(negedge clk);
    check("R1", "done after reset", int'(done | xferFail | startErr | rdStrobe | wrStrobe), 0);

    // R3 R4: each type, request held, both directions
    for (int ty = 0; ty < 4; ty++) begin
      for (int d = 0; d < 2; d++) begin
        clearFlags();
        dmaReq = 1'b1;
        launch(ty, d[0], 3);
        check("R2", "busy after start", int'(busy), 1);
        check("R2", "residue after start", int'(residue), 3);
        waitIdle();
        check("R3", "strobe run length", lastStrobeRun, actTicks[ty]);
        check("R3", "ack run over held request", lastAckRun, 3 * (actTicks[ty] + recTicks[ty]));
        check("R7", "done seen, no fail", int'(sawDone && !sawFail), 1);
        check("R7", "residue at done", lastResidueAtDone, 0);
      end
    end

    // R6: request drops mid-transfer, then returns; R11: inputs flip during transfer
    clearFlags();
    dmaReq = 1'b1;
    launch(1, 1'b1, 4);
    timingType = 2'd3; dirWrite = 1'b0;   // R11 must be ignored
    repeat (9) @(negedge clk);
    dmaReq = 1'b0;
    repeat (12) @(negedge clk);
    check("R6", "ack low while request low", int'(dmaAck), 0);
    check("R6", "residue held while waiting", int'(residue), 2);
    dmaReq = 1'b1;
    waitIdle();
    check("R11", "strobe run kept latched type", lastStrobeRun, actTicks[1]);
    check("R7", "stalled transfer completes", int'(sawDone && !sawFail), 1);

    // R8: abort while waiting for request
    clearFlags();
    dmaReq = 1'b1;
    launch(2, 1'b0, 6);
    repeat (7) @(negedge clk);
    dmaReq = 1'b0;
    abort = 1'b1;
    waitIdle();
    abort = 1'b0;
    check("R8", "abort flags failure", int'(sawFail), 1);
    check("R8", "residue keeps words left", lastResidueAtDone, 4);

    // R8: abort before any word
    clearFlags();
    dmaReq = 1'b0;
    launch(0, 1'b1, 5);
    abort = 1'b1;
    waitIdle();
    abort = 1'b0;
    check("R8", "early abort residue", lastResidueAtDone, 5);
    check("R8", "early abort no ack", int'(sawAck), 0);

    // R8: request has priority over abort
    clearFlags();
    dmaReq = 1'b1;
    abort = 1'b1;
    launch(3, 1'b0, 3);
    waitIdle();
    abort = 1'b0;
    check("R8", "request beats abort", int'(sawFail), 0);

    // R9: start while busy is rejected
    clearFlags();
    dmaReq = 1'b1;
    launch(2, 1'b1, 4);
    repeat (2) @(negedge clk);
    launch(0, 1'b0, 9);
    waitIdle();
    check("R9", "startErr seen", int'(sawErr), 1);
    check("R9", "second start ignored", lastAckRun, 4 * (actTicks[2] + recTicks[2]));

    // R10: zero count
    clearFlags();
    launch(0, 1'b0, 0);
    @(posedge clk); #6;
    check("R10", "done two cycles after start", int'(done), 1);
    check("R10", "no fail on zero count", int'(xferFail), 0);
    waitIdle();
    check("R10", "no ack on zero count", int'(sawAck), 0);

    dmaReq = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule